// File: doc/BRIEF.md
# Multidrop 9-bit Receive Address Filter

This block sits between a serial receiver and its receive FIFO on a 9-bit multidrop link. Each received character arrives as a byte plus a ninth bit that marks it as an address (1) or as data (0). The filter decides whether the character is written into the FIFO. It raises single-cycle pulses for data-ready, address-seen and overrun, and it keeps a receiver-disable flag that software can write and that hardware also updates.

The block has three modes. With multidrop off, every character passes through unchanged. In software-managed mode, a disabled receiver stores only address characters. An enabled receiver stores everything and flags each address, so that software can choose whether to disable the receiver again. In automatic mode, address characters are compared with an 8-bit match value. A matching address opens the receiver by clearing the disable flag. A non-matching address closes it by setting the flag. Hardware does both without software action.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `fifo_push`, `irq_rdy`, `irq_addr`, `irq_ovr` and `rx_disabled` are all 0.
- R2: With `cfg_mdrop_en`=0, every character is pushed with `fifo_wdata` = {`rx_addr_flag`, `rx_data`} (flag in bit 8), and `irq_addr` stays 0.
- R3: Software mode (`cfg_mdrop_en`=1, `cfg_auto_en`=0) with the receiver disabled: data characters (flag 0) are not pushed. Address characters (flag 1) are pushed and raise `irq_rdy`.
- R4: Software mode with the receiver enabled: every character is pushed, and each address character also raises `irq_addr`.
- R5: Automatic mode (`cfg_mdrop_en`=1, `cfg_auto_en`=1) with the receiver disabled: data characters and address characters that differ from `match_addr` are not pushed, and `rx_disabled` stays 1.
- R6: Automatic mode with the receiver disabled: an address equal to `match_addr` is pushed with bit 8 set, raises `irq_rdy`, and clears `rx_disabled`.
- R7: Automatic mode with the receiver enabled: data and matching addresses are pushed. A non-matching address is not pushed, and it sets `rx_disabled`.
- R8: A pulse on `sw_dis_wr` loads `sw_dis_val` into `rx_disabled`. When hardware updates the flag in the same cycle, the hardware value wins.
- R9: A character that would be pushed while `fifo_full`=1 is dropped. No push occurs, and `irq_ovr` pulses instead.
- R10: Every output pulse appears exactly one cycle after the `rx_valid` cycle that caused it and lasts one cycle. `irq_rdy` accompanies every push, and all pulses are 0 in cycles that follow no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mdrop_en | input | 1 | Enables 9-bit multidrop filtering |
| cfg_auto_en | input | 1 | Selects automatic address matching (needs cfg_mdrop_en) |
| match_addr | input | 8 | Station address for automatic mode |
| sw_dis_wr | input | 1 | Software write strobe for the disable flag |
| sw_dis_val | input | 1 | Value written into the disable flag |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_addr_flag | input | 1 | Ninth bit: 1 address, 0 data |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 9 | FIFO entry {flag, byte} |
| irq_rdy | output | 1 | Data-ready pulse |
| irq_addr | output | 1 | Address-received pulse (software mode) |
| irq_ovr | output | 1 | Overrun pulse |
| rx_disabled | output | 1 | Current receiver-disable flag |

## Verification
A wrong disable flag does not show at once. It shows on the next character whose fate depends on the flag: a data byte that is stored when it should be dropped, or dropped when it should be stored. For that reason the bench follows every flag change with such a character and compares `rx_disabled` directly on every event. A wrong match decision shows one cycle later, both as a missing or extra push and as a wrong flag value. The collision cases drive a software write and a hardware update in the same cycle, so that a reversed priority shows as the wrong flag value on the next cycle.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_SW   = 2'd1,
    MODE_AUTO = 2'd2
  } mdrop_mode_e;

  typedef struct packed {
    logic store;     // character should be written
    logic addr_irq;  // address-seen pulse request
    logic hw_set;    // hardware closes the receiver
    logic hw_clr;    // hardware opens the receiver
  } mdrop_dec_t;
endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_addr_flag,
  input  logic              mdrop_en,
  input  logic              auto_en,
  input  logic              disabled,
  input  logic [DATA_W-1:0] match_addr,
  output mdrop_dec_t        dec
);
  mdrop_mode_e mode;
  logic        hit;

  always_comb begin
    if (!mdrop_en)    mode = MODE_PASS;
    else if (auto_en) mode = MODE_AUTO;
    else              mode = MODE_SW;
  end

  assign hit = (rx_data == match_addr);

  always_comb begin
    dec = '0;
    if (rx_valid) begin
      unique case (mode)
        MODE_PASS: dec.store = 1'b1;
        MODE_SW: begin
          if (disabled) begin
            dec.store = rx_addr_flag;
          end else begin
            dec.store    = 1'b1;
            dec.addr_irq = rx_addr_flag;
          end
        end
        MODE_AUTO: begin
          if (disabled) begin
            dec.store  = rx_addr_flag && hit;
            dec.hw_clr = rx_addr_flag && hit;
          end else begin
            dec.store  = !(rx_addr_flag && !hit);
            dec.hw_set = rx_addr_flag && !hit;
          end
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_dis_flag.sv
module mdrop_dis_flag (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_wr,
  input  logic sw_val,
  output logic disabled
);
  always_ff @(posedge clk) begin
    if (rst)          disabled <= 1'b0;
    else if (hw_set)  disabled <= 1'b1;
    else if (hw_clr)  disabled <= 1'b0;
    else if (sw_wr)   disabled <= sw_val;
  end
endmodule

// File: rtl/mdrop_push_stage.sv
module mdrop_push_stage
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ENTRY_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  mdrop_dec_t         dec,
  input  logic               fifo_full,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               rx_addr_flag,
  output logic               fifo_push,
  output logic [ENTRY_W-1:0] fifo_wdata,
  output logic               irq_rdy,
  output logic               irq_addr,
  output logic               irq_ovr
);
  logic do_push;
  assign do_push = dec.store && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
      irq_rdy    <= 1'b0;
      irq_addr   <= 1'b0;
      irq_ovr    <= 1'b0;
    end else begin
      fifo_push <= do_push;
      irq_rdy   <= do_push;
      irq_addr  <= dec.addr_irq;
      irq_ovr   <= dec.store && fifo_full;
      if (do_push) fifo_wdata <= {rx_addr_flag, rx_data};
    end
  end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ENTRY_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mdrop_en,
  input  logic               cfg_auto_en,
  input  logic [DATA_W-1:0]  match_addr,
  input  logic               sw_dis_wr,
  input  logic               sw_dis_val,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               rx_addr_flag,
  input  logic               fifo_full,
  output logic               fifo_push,
  output logic [ENTRY_W-1:0] fifo_wdata,
  output logic               irq_rdy,
  output logic               irq_addr,
  output logic               irq_ovr,
  output logic               rx_disabled
);
  mdrop_dec_t dec;

  mdrop_classify #(.DATA_W(DATA_W)) u_classify (
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_addr_flag(rx_addr_flag),
    .mdrop_en    (cfg_mdrop_en),
    .auto_en     (cfg_auto_en),
    .disabled    (rx_disabled),
    .match_addr  (match_addr),
    .dec         (dec)
  );

  mdrop_dis_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (dec.hw_set),
    .hw_clr  (dec.hw_clr),
    .sw_wr   (sw_dis_wr),
    .sw_val  (sw_dis_val),
    .disabled(rx_disabled)
  );

  mdrop_push_stage #(.DATA_W(DATA_W)) u_push (
    .clk         (clk),
    .rst         (rst),
    .dec         (dec),
    .fifo_full   (fifo_full),
    .rx_data     (rx_data),
    .rx_addr_flag(rx_addr_flag),
    .fifo_push   (fifo_push),
    .fifo_wdata  (fifo_wdata),
    .irq_rdy     (irq_rdy),
    .irq_addr    (irq_addr),
    .irq_ovr     (irq_ovr)
  );
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_mdrop_en,
  input logic              cfg_auto_en,
  input logic [DATA_W-1:0] match_addr,
  input logic              sw_dis_wr,
  input logic              sw_dis_val,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_addr_flag,
  input logic              fifo_full,
  input logic              fifo_push,
  input logic [DATA_W:0]   fifo_wdata,
  input logic              irq_rdy,
  input logic              irq_addr,
  input logic              irq_ovr,
  input logic              rx_disabled
);
  p_pass_payload_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !fifo_full && !cfg_mdrop_en) |=>
      (fifo_push && fifo_wdata == $past({rx_addr_flag, rx_data}) && !irq_addr));

  p_auto_drop_data_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_mdrop_en && cfg_auto_en && rx_disabled && !rx_addr_flag && !sw_dis_wr) |=>
      (!fifo_push && rx_disabled));

  p_auto_close_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_mdrop_en && cfg_auto_en && !rx_disabled && rx_addr_flag
     && rx_data != match_addr) |=> (!fifo_push && rx_disabled));

  p_sw_write_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_dis_wr && !rx_valid) |=> (rx_disabled == $past(sw_dis_val)));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fifo_full) |=> !fifo_push);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> (!fifo_push && !irq_rdy && !irq_addr && !irq_ovr));

  p_rdy_with_push_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (irq_rdy && !irq_ovr));
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mdrop_rx_filter_bench.sv
module mdrop_rx_filter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mdrop_en = 1'b0, cfg_auto_en = 1'b0;
  logic [7:0] match_addr = 8'h00;
  logic       sw_dis_wr = 1'b0, sw_dis_val = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_addr_flag = 1'b0;
  logic       fifo_full = 1'b0;
  logic       fifo_push, irq_rdy, irq_addr, irq_ovr, rx_disabled;
  logic [8:0] fifo_wdata;

  always #5 clk = ~clk;

  mdrop_rx_filter u_mdrop_rx_filter (.*);

  typedef struct {
    logic       push;
    logic [8:0] wdata;
    logic       addr;
    logic       ovr;
    logic       dis;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic model_dis = 1'b0;
  logic event_seen = 1'b0;
  logic running = 1'b0;

  always @(posedge clk) event_seen <= running && (rx_valid || sw_dis_wr);

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (event_seen) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (fifo_push !== e.push || irq_rdy !== e.push || irq_addr !== e.addr ||
            irq_ovr !== e.ovr || rx_disabled !== e.dis ||
            (e.push && fifo_wdata !== e.wdata)) begin
          errors++;
          $display("FAIL %s: got push=%b rdy=%b wdata=%h addr=%b ovr=%b dis=%b exp push=%b wdata=%h addr=%b ovr=%b dis=%b",
                   e.tag, fifo_push, irq_rdy, fifo_wdata, irq_addr, irq_ovr, rx_disabled,
                   e.push, e.wdata, e.addr, e.ovr, e.dis);
        end
      end else begin
        checks++;
        if (fifo_push || irq_rdy || irq_addr || irq_ovr) begin
          errors++;
          $display("FAIL R10 idle: got push=%b rdy=%b addr=%b ovr=%b exp all 0",
                   fifo_push, irq_rdy, irq_addr, irq_ovr);
        end
      end
    end
  end

  // driver: one event (character and/or software write) per call
  task automatic send(input logic v, input logic [7:0] d, input logic f,
                      input logic wr, input logic wv, input string tag);
    exp_t e;
    logic want = 1'b0, hs = 1'b0, hc = 1'b0;
    e.addr = 1'b0;
    if (v) begin
      if (!cfg_mdrop_en) want = 1'b1;
      else if (!cfg_auto_en) begin
        want   = model_dis ? f : 1'b1;
        e.addr = !model_dis && f;
      end else if (model_dis) begin
        want = f && (d == match_addr);
        hc   = want;
      end else begin
        hs   = f && (d != match_addr);
        want = !hs;
      end
    end
    e.push  = want && !fifo_full;
    e.ovr   = want && fifo_full;
    e.wdata = {f, d};
    if (hs) model_dis = 1'b1;
    else if (hc) model_dis = 1'b0;
    else if (wr) model_dis = wv;
    e.dis = model_dis;
    e.tag = tag;
    exp_q.push_back(e);
    rx_valid = v; rx_data = d; rx_addr_flag = f;
    sw_dis_wr = wr; sw_dis_val = wv;
    @(negedge clk);
    rx_valid = 1'b0; sw_dis_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (fifo_push || irq_rdy || irq_addr || irq_ovr || rx_disabled) begin
      errors++;
      $display("FAIL R1 reset: got push=%b rdy=%b addr=%b ovr=%b dis=%b exp 0",
               fifo_push, irq_rdy, irq_addr, irq_ovr, rx_disabled);
    end
    running = 1'b1;
    idle(2);

    // R2 pass-through, back to back
    send(1, 8'hA5, 0, 0, 0, "R2 data");
    send(1, 8'h3C, 1, 0, 0, "R2 addr no irq");
    idle(2);

    // software mode
    cfg_mdrop_en = 1'b1;
    send(0, 8'h00, 0, 1, 1, "R8 sw set");
    send(1, 8'h11, 0, 0, 0, "R3 data dropped");
    send(1, 8'h22, 1, 0, 0, "R3 addr stored");
    send(0, 8'h00, 0, 1, 0, "R8 sw clear");
    send(1, 8'h33, 0, 0, 0, "R4 data stored");
    send(1, 8'h44, 1, 0, 0, "R4 addr irq");
    idle(2);

    // automatic mode
    cfg_auto_en = 1'b1; match_addr = 8'h5A;
    send(0, 8'h00, 0, 1, 1, "R8 sw set");
    send(1, 8'h5A, 0, 0, 0, "R5 data dropped");
    send(1, 8'h12, 1, 0, 0, "R5 nonmatch dropped");
    send(1, 8'h5A, 1, 0, 0, "R6 match opens");
    send(1, 8'h77, 0, 0, 0, "R7 data stored");
    send(1, 8'h5A, 1, 0, 0, "R7 match stored");
    send(1, 8'h99, 1, 0, 0, "R7 nonmatch closes");
    send(1, 8'h55, 0, 0, 0, "R5 data after close");
    send(1, 8'h5A, 1, 1, 1, "R8 hw clear beats sw set");
    send(1, 8'hA5, 1, 1, 0, "R8 hw set beats sw clear");
    send(1, 8'h01, 0, 0, 0, "R8 flag held");
    idle(2);

    // overrun
    fifo_full = 1'b1;
    send(1, 8'h5A, 1, 0, 0, "R9 match while full");
    send(1, 8'h66, 0, 0, 0, "R9 data while full");
    cfg_mdrop_en = 1'b0; cfg_auto_en = 1'b0;
    send(1, 8'hC3, 0, 0, 0, "R9 pass while full");
    fifo_full = 1'b0;
    send(1, 8'hC4, 1, 0, 0, "R2 after full");
    idle(3);

    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule